// File: doc/BRIEF.md
# Edge-Triggered Conversion Buffer Controller

This block turns transitions on an external trigger wire into single sample conversions. The trigger passes through a synchroniser. An edge detector then watches it for the edge kind chosen in a control register: rising, falling or both. Each accepted edge sends one request to an attached converter over a request/valid handshake. The returned sample is pushed into a circular buffer held in a shared result RAM.

Two boundary registers split the RAM into two windows. The lower window belongs to group 0 and the upper one to group 1. A control bit chooses the group whose window collects results. Software drains the active window through a pop port. A threshold register sets how many stored results raise a sticky status flag. That flag, gated by an enable bit, drives the interrupt line.

A trigger edge that lands while a conversion is still outstanding is dropped and recorded. A result that finds its window full is also dropped and recorded.

Top module: `conv_trig_buf`

## Requirements
- R1: Control register (address 0) bits [1:0] select the trigger edge: 0 = falling, 1 = rising, 2 or 3 = both edges. Each selected edge produces exactly one single-cycle `conv_req` pulse, and an unselected edge produces none.
- R2: After reset the edge selection is falling, the interrupt enable (control bit 2) and group select (control bit 3) are 0, and `conv_req`, `irq`, all status outputs and `fill_count` are 0. Boundary A resets to DEPTH/2, boundary B to DEPTH and the threshold to DEPTH/2.
- R3: A selected edge seen while a conversion is outstanding (from the `conv_req` pulse up to and including the cycle `conv_valid` arrives) starts nothing and sets the sticky `sts_trig_ovr`. Writing 1 to bit 1 of the status register (address 4) clears it.
- R4: Results are returned in arrival order. A pop request on a non-empty buffer is answered with `rd_valid` and the oldest result one clock later.
- R5: Group 0 owns RAM entries [0, A) and group 1 owns [A, B). Boundary A is written at address 1 and boundary B at address 2, and written values above DEPTH are clamped to DEPTH. When B is at most A, group 1 has zero capacity.
- R6: A result that arrives when the active window holds as many results as its capacity is discarded, and stored results are unchanged. The sticky `sts_data_ovr` is set and is cleared by writing 1 to status bit 2.
- R7: When the threshold (address 3) is non-zero and `fill_count` is at or above it, `sts_thr` is set in the next cycle. Writing 1 to status bit 0 clears it for one cycle, after which it sets again if the condition still holds.
- R8: `irq` is high exactly when `sts_thr` is high and the interrupt enable bit is set.
- R9: Any write to addresses 0 to 2 empties the buffer. A pop request on an empty buffer yields no `rd_valid` and leaves `fill_count` at 0.
- R10: A level change on `trig_in` set up before clock edge k produces `conv_req` after clock edge k+2 (two synchroniser stages, one request register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous trigger line |
| conv_req | output | 1 | One-cycle request to start a conversion |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Register address: 0 control, 1 bound A, 2 bound B, 3 threshold, 4 status clear |
| cfg_wdata | input | CFG_W | Register write data |
| rd_req | input | 1 | Pop the oldest result |
| rd_valid | output | 1 | Pop data valid |
| rd_data | output | DATA_W | Popped result |
| fill_count | output | $clog2(DEPTH+1) | Results held in the active window |
| sts_thr | output | 1 | Sticky threshold reached flag |
| sts_trig_ovr | output | 1 | Sticky flag for an ignored trigger |
| sts_data_ovr | output | 1 | Sticky flag for a discarded result |
| irq | output | 1 | Interrupt request |

## Verification
The trigger overrun is the hardest case to reach from the ports. The second edge must pass the synchroniser and land inside the window between the request and the result. The bench's converter model therefore takes a programmable response delay. That delay is stretched to twenty cycles while the trigger line is toggled twice a few cycles apart. Group 1 with zero capacity is also reached deliberately: boundary B is programmed below boundary A with group 1 selected before a conversion is fired.

// File: rtl/conv_pkg.sv
package conv_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_BOTH_ALT = 2'd3
   } edge_mode_e;

   localparam logic [2:0] REG_CTRL  = 3'd0;
   localparam logic [2:0] REG_BND_A = 3'd1;
   localparam logic [2:0] REG_BND_B = 3'd2;
   localparam logic [2:0] REG_THR   = 3'd3;
   localparam logic [2:0] REG_STAT  = 3'd4;

endpackage

// File: rtl/conv_trig_edge.sv
module conv_trig_edge
   import conv_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  edge_mode_e mode,
   output logic       hit
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("conv_trig_edge: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= trig_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

   always_comb begin
      case (mode)
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         default:   hit = rise | fall;
      endcase
   end

endmodule

// File: rtl/conv_res_fifo.sv
module conv_res_fifo #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [CW-1:0]     base,
   input  logic [CW-1:0]     size,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     count,
   output logic              drop
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CW-1:0]     wr_off, rd_off;
   logic              full, do_wr, do_rd;

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("conv_res_fifo: DEPTH must be at least 4");
      end
   endgenerate

   assign full  = (count >= size);
   assign do_wr = wr_en && !full && !flush;
   assign do_rd = rd_en && (count != '0) && !flush;
   assign drop  = wr_en && full && !flush;

   function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] off,
                                              input logic [CW-1:0] lim);
      return (off + CW'(1) >= lim) ? '0 : off + CW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_off   <= '0;
         rd_off   <= '0;
         count    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= do_rd;
         if (flush) begin
            wr_off <= '0;
            rd_off <= '0;
            count  <= '0;
         end else begin
            if (do_wr) wr_off <= wrap_inc(wr_off, size);
            if (do_rd) rd_off <= wrap_inc(rd_off, size);
            case ({do_wr, do_rd})
               2'b10:   count <= count + CW'(1);
               2'b01:   count <= count - CW'(1);
               default: count <= count;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[AW'(base + wr_off)] <= wr_data;
      if (do_rd) rd_data <= mem[AW'(base + rd_off)];
   end

endmodule

// File: rtl/conv_irq_stat.sv
module conv_irq_stat #(
   parameter int CW = 7
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] thresh,
   input  logic [2:0]    clr,
   input  logic          set_trig,
   input  logic          set_data,
   input  logic          irq_en,
   output logic          thr_flag,
   output logic          trig_ovr,
   output logic          data_ovr,
   output logic          irq
);

   logic reach;

   assign reach = (thresh != '0) && (count >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_flag <= 1'b0;
         trig_ovr <= 1'b0;
         data_ovr <= 1'b0;
      end else begin
         if (clr[0])     thr_flag <= 1'b0;
         else if (reach) thr_flag <= 1'b1;

         if (set_trig)    trig_ovr <= 1'b1;
         else if (clr[1]) trig_ovr <= 1'b0;

         if (set_data)    data_ovr <= 1'b1;
         else if (clr[2]) data_ovr <= 1'b0;
      end
   end

   assign irq = thr_flag & irq_en;

endmodule

// File: rtl/conv_trig_buf.sv
module conv_trig_buf
   import conv_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int DEPTH       = 64,
   parameter int CFG_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CW         = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_in,
   output logic              conv_req,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     fill_count,
   output logic              sts_thr,
   output logic              sts_trig_ovr,
   output logic              sts_data_ovr,
   output logic              irq
);

   generate
      if (CFG_W < CW || CFG_W < 4) begin : g_bad_cfg
         $error("conv_trig_buf: CFG_W too narrow for the register fields");
      end
   endgenerate

   edge_mode_e    edge_mode;
   logic          irq_en, grp_sel;
   logic [CW-1:0] bnd_a, bnd_b, thresh_r;
   logic [CW-1:0] cur_base, cur_size;
   logic          hit, busy, flush, drop;
   logic [2:0]    clr_mask;

   function automatic logic [CW-1:0] clamp_bound(input logic [CFG_W-1:0] v);
      return (v > CFG_W'(DEPTH)) ? CW'(DEPTH) : v[CW-1:0];
   endfunction

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_mode <= EDGE_FALL;
         irq_en    <= 1'b0;
         grp_sel   <= 1'b0;
         bnd_a     <= CW'(DEPTH / 2);
         bnd_b     <= CW'(DEPTH);
         thresh_r  <= CW'(DEPTH / 2);
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_CTRL: begin
               edge_mode <= edge_mode_e'(cfg_wdata[1:0]);
               irq_en    <= cfg_wdata[2];
               grp_sel   <= cfg_wdata[3];
            end
            REG_BND_A: bnd_a    <= clamp_bound(cfg_wdata);
            REG_BND_B: bnd_b    <= clamp_bound(cfg_wdata);
            REG_THR:   thresh_r <= clamp_bound(cfg_wdata);
            default: ;
         endcase
      end
   end

   assign flush    = cfg_we && (cfg_addr <= REG_BND_B);
   assign clr_mask = (cfg_we && cfg_addr == REG_STAT) ? cfg_wdata[2:0] : 3'b000;

   // window of the active group
   always_comb begin
      if (grp_sel) begin
         cur_base = bnd_a;
         cur_size = (bnd_b > bnd_a) ? bnd_b - bnd_a : '0;
      end else begin
         cur_base = '0;
         cur_size = bnd_a;
      end
   end

   conv_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .mode    (edge_mode),
      .hit     (hit)
   );

   // single-conversion sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         conv_req <= 1'b0;
      end else begin
         conv_req <= 1'b0;
         if (busy) begin
            if (conv_valid) busy <= 1'b0;
         end else if (hit) begin
            busy     <= 1'b1;
            conv_req <= 1'b1;
         end
      end
   end

   conv_res_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .base     (cur_base),
      .size     (cur_size),
      .wr_en    (busy && conv_valid),
      .wr_data  (conv_data),
      .rd_en    (rd_req),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .count    (fill_count),
      .drop     (drop)
   );

   conv_irq_stat #(.CW(CW)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (fill_count),
      .thresh   (thresh_r),
      .clr      (clr_mask),
      .set_trig (hit && busy),
      .set_data (drop),
      .irq_en   (irq_en),
      .thr_flag (sts_thr),
      .trig_ovr (sts_trig_ovr),
      .data_ovr (sts_data_ovr),
      .irq      (irq)
   );

endmodule

// File: rtl/conv_trig_buf_chk.sv
module conv_trig_buf_chk #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
)(
   input logic          clk,
   input logic          rst_n,
   input logic          conv_req,
   input logic          conv_valid,
   input logic          busy,
   input logic          rd_req,
   input logic          rd_valid,
   input logic          cfg_we,
   input logic [CW-1:0] fill_count,
   input logic [CW-1:0] cur_size,
   input logic [CW-1:0] thresh_r,
   input logic          sts_thr,
   input logic          sts_data_ovr,
   input logic          irq
);

   a_r1_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_valid |=> busy);

   a_r3_no_req_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !conv_req);

   a_r5_fill_within_window: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= cur_size);

   a_r6_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_valid && !cfg_we && (fill_count >= cur_size) |=> sts_data_ovr);

   a_r7_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_thr) |-> ($past(thresh_r) != '0) && ($past(fill_count) >= $past(thresh_r)));

   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> sts_thr);

   a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_count == '0) && rd_req |=> !rd_valid);

endmodule

bind conv_trig_buf conv_trig_buf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_req     (conv_req),
   .conv_valid   (conv_valid),
   .busy         (busy),
   .rd_req       (rd_req),
   .rd_valid     (rd_valid),
   .cfg_we       (cfg_we),
   .fill_count   (fill_count),
   .cur_size     (cur_size),
   .thresh_r     (thresh_r),
   .sts_thr      (sts_thr),
   .sts_data_ovr (sts_data_ovr),
   .irq          (irq)
);

// File: tb/conv_trig_buf_tb_top.sv
`timescale 1ns/1ps
module conv_trig_buf_tb_top;

   localparam int DATA_W = 12;
   localparam int DEPTH  = 64;
   localparam int CFG_W  = 16;
   localparam int CW     = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig_in = 1'b0;
   logic              conv_req;
   logic              conv_valid = 1'b0;
   logic [DATA_W-1:0] conv_data = '0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_addr = '0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic              rd_req = 1'b0;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic [CW-1:0]     fill_count;
   logic              sts_thr, sts_trig_ovr, sts_data_ovr, irq;

   int n_chk = 0;
   int n_bad = 0;
   int req_cnt = 0;
   int next_val = 'h100;
   int conv_lat = 1;
   bit pend = 0;
   int dly = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   conv_trig_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CFG_W(CFG_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .conv_req(conv_req),
      .conv_valid(conv_valid), .conv_data(conv_data), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data), .fill_count(fill_count),
      .sts_thr(sts_thr), .sts_trig_ovr(sts_trig_ovr),
      .sts_data_ovr(sts_data_ovr), .irq(irq)
   );

   // converter model: answers each request after conv_lat cycles
   always @(negedge clk) begin
      conv_valid <= 1'b0;
      if (pend) begin
         if (dly == 0) begin
            conv_valid <= 1'b1;
            conv_data  <= DATA_W'(next_val);
            next_val   = next_val + 1;
            pend       = 0;
         end else begin
            dly = dly - 1;
         end
      end
      if (conv_req) begin
         req_cnt = req_cnt + 1;
         pend    = 1;
         dly     = conv_lat;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic cfg_write(input logic [2:0] a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CFG_W'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic toggle_and_wait();
      @(negedge clk);
      trig_in = ~trig_in;
      settle(conv_lat + 8);
   endtask

   task automatic pop_expect(input int exp, input string tag);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk(rd_valid === 1'b1, tag, int'(rd_valid), 1);
      chk(int'(rd_data) == (exp & 'hFFF), tag, int'(rd_data), exp & 'hFFF);
   endtask

   task automatic pop_empty(input string tag);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      chk(rd_valid === 1'b0, tag, int'(rd_valid), 0);
      chk(fill_count == 0, tag, int'(fill_count), 0);
   endtask

   // R2: reset state and default falling edge
   task automatic t_reset();
      int r0;
      @(negedge clk);
      chk(conv_req == 0, "R2 conv_req after reset", int'(conv_req), 0);
      chk(fill_count == 0, "R2 fill after reset", int'(fill_count), 0);
      chk(irq == 0 && sts_thr == 0, "R2 irq after reset", int'(irq), 0);
      chk(sts_trig_ovr == 0 && sts_data_ovr == 0, "R2 overrun flags", int'(sts_trig_ovr), 0);
      r0 = req_cnt;
      toggle_and_wait();
      chk(req_cnt == r0, "R2 rising ignored by default falling", req_cnt - r0, 0);
      toggle_and_wait();
      chk(req_cnt == r0 + 1, "R2 falling accepted by default", req_cnt - r0, 1);
      chk(fill_count == 1, "R2 result stored", int'(fill_count), 1);
   endtask

   // R10: two sync stages plus the request register
   task automatic t_latency();
      int r0;
      cfg_write(3'd0, 1);
      r0 = req_cnt;
      @(negedge clk); trig_in = 1'b1;
      @(negedge clk); chk(conv_req == 0, "R10 no request after edge 1", int'(conv_req), 0);
      @(negedge clk); chk(conv_req == 0, "R10 no request after edge 2", int'(conv_req), 0);
      @(negedge clk); chk(conv_req == 1, "R10 request after edge 3", int'(conv_req), 1);
      settle(10);
      toggle_and_wait();
      chk(req_cnt == r0 + 1, "R1 rising mode ignores falling", req_cnt - r0, 1);
   endtask

   // R1: both-edge encodings
   task automatic t_both();
      int r0;
      cfg_write(3'd0, 2);
      r0 = req_cnt;
      for (int i = 0; i < 4; i++) toggle_and_wait();
      chk(req_cnt == r0 + 4, "R1 mode 2 counts both edges", req_cnt - r0, 4);
      chk(fill_count == 4, "R1 four results stored", int'(fill_count), 4);
      cfg_write(3'd0, 3);
      r0 = req_cnt;
      toggle_and_wait();
      toggle_and_wait();
      chk(req_cnt == r0 + 2, "R1 mode 3 counts both edges", req_cnt - r0, 2);
   endtask

   // R4: arrival order
   task automatic t_order();
      int v0;
      cfg_write(3'd0, 2);
      v0 = next_val;
      for (int i = 0; i < 5; i++) toggle_and_wait();
      for (int i = 0; i < 5; i++) pop_expect(v0 + i, "R4 pop order");
      chk(fill_count == 0, "R4 drained", int'(fill_count), 0);
   endtask

   // R3: edge during an outstanding conversion
   task automatic t_busy();
      int r0;
      conv_lat = 20;
      cfg_write(3'd0, 2);
      r0 = req_cnt;
      @(negedge clk); trig_in = ~trig_in;
      settle(6);
      trig_in = ~trig_in;
      settle(40);
      chk(req_cnt == r0 + 1, "R3 second edge ignored", req_cnt - r0, 1);
      chk(sts_trig_ovr == 1, "R3 trigger overrun set", int'(sts_trig_ovr), 1);
      chk(fill_count == 1, "R3 one result", int'(fill_count), 1);
      cfg_write(3'd4, 2);
      chk(sts_trig_ovr == 0, "R3 trigger overrun cleared", int'(sts_trig_ovr), 0);
      conv_lat = 1;
   endtask

   // R5, R6, R9: windows, full drop, flush, empty pop
   task automatic t_groups();
      int v0;
      cfg_write(3'd3, 0);
      cfg_write(3'd1, 4);
      cfg_write(3'd0, 2);
      v0 = next_val;
      for (int i = 0; i < 6; i++) toggle_and_wait();
      chk(fill_count == 4, "R5 group0 capacity A", int'(fill_count), 4);
      chk(sts_data_ovr == 1, "R6 data overrun set", int'(sts_data_ovr), 1);
      for (int i = 0; i < 4; i++) pop_expect(v0 + i, "R6 stored data kept");
      pop_empty("R9 pop on empty");
      cfg_write(3'd4, 4);
      chk(sts_data_ovr == 0, "R6 data overrun cleared", int'(sts_data_ovr), 0);

      cfg_write(3'd2, 10);
      cfg_write(3'd0, 10);
      v0 = next_val;
      for (int i = 0; i < 8; i++) toggle_and_wait();
      chk(fill_count == 6, "R5 group1 capacity B-A", int'(fill_count), 6);
      chk(sts_data_ovr == 1, "R6 group1 overrun", int'(sts_data_ovr), 1);
      pop_expect(v0, "R5 group1 first entry");
      cfg_write(3'd4, 4);

      cfg_write(3'd2, 3);
      toggle_and_wait();
      chk(fill_count == 0, "R5 group1 zero capacity", int'(fill_count), 0);
      chk(sts_data_ovr == 1, "R5 zero capacity drops", int'(sts_data_ovr), 1);
      cfg_write(3'd4, 4);

      cfg_write(3'd2, 200);
      cfg_write(3'd1, 32);
      cfg_write(3'd0, 2);
      v0 = next_val;
      toggle_and_wait();
      pop_expect(v0, "R5 clamped bound usable");
   endtask

   // R7, R8: threshold flag and gating
   task automatic t_thresh();
      cfg_write(3'd3, 3);
      cfg_write(3'd0, 6);
      toggle_and_wait();
      toggle_and_wait();
      chk(sts_thr == 0, "R7 below threshold", int'(sts_thr), 0);
      chk(irq == 0, "R8 no irq below threshold", int'(irq), 0);
      toggle_and_wait();
      chk(sts_thr == 1, "R7 threshold reached", int'(sts_thr), 1);
      chk(irq == 1, "R8 irq enabled", int'(irq), 1);
      cfg_write(3'd4, 1);
      chk(sts_thr == 0, "R7 cleared by write", int'(sts_thr), 0);
      @(negedge clk);
      chk(sts_thr == 1, "R7 re-asserts at threshold", int'(sts_thr), 1);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      cfg_write(3'd4, 1);
      settle(2);
      chk(sts_thr == 0, "R7 stays clear below threshold", int'(sts_thr), 0);
      toggle_and_wait();
      chk(sts_thr == 1, "R7 set again", int'(sts_thr), 1);
      cfg_write(3'd0, 2);
      chk(sts_thr == 1, "R8 flag sticky", int'(sts_thr), 1);
      chk(irq == 0, "R8 irq masked", int'(irq), 0);
      chk(fill_count == 0, "R9 control write flushes", int'(fill_count), 0);
      cfg_write(3'd4, 1);
   endtask

   // R9: boundary write flushes
   task automatic t_flush();
      cfg_write(3'd3, 0);
      cfg_write(3'd0, 2);
      for (int i = 0; i < 3; i++) toggle_and_wait();
      chk(fill_count == 3, "R9 filled before flush", int'(fill_count), 3);
      cfg_write(3'd2, 64);
      chk(fill_count == 0, "R9 bound write flushes", int'(fill_count), 0);
      pop_empty("R9 pop after flush");
   endtask

   initial begin
      settle(5);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_both();
      t_order();
      t_busy();
      t_groups();
      t_thresh();
      t_flush();
      settle(4);
      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         report();
         $finish;
      end
   end

endmodule